// File: doc/BRIEF.md
# PC-relative address instruction generator

This block turns an address-load request into one or two data-processing instructions. Each instruction computes a label address relative to the program counter. The request gives the address of the instruction being rewritten, the address of the target label, a destination register and a long-form select.

The program counter seen by the instruction is its own address plus 8, because of the fetch, decode and execute pipeline. The block subtracts that value from the label address and looks at the sign of the result. A label ahead of the counter gives an add, and a label behind it gives a subtract of the magnitude.

- **Short offsets:** a magnitude of at most 255 becomes a single instruction.
- **Long form:** a larger magnitude can be split across two chained instructions when the long form is selected. The first instruction applies 255 to the counter. The second applies the remainder to the destination register.
- **Errors:** in every other case the block reports an out-of-range error and emits no instruction.

One request is accepted per cycle. The result appears one cycle later.

Top module: `pcrel_gen`

## Requirements
- R1: While rst_ni is low, and after reset until the first request, valid_o, err_o and count_o are 0 and both words are zero.
- R2: A request taken with valid_i high in one cycle is presented with valid_o high after the next rising clock edge. A cycle with valid_i low gives valid_o low, count_o 0, err_o 0 and both words zero in the following cycle.
- R3: The offset is label_addr_i minus (instr_addr_i + 8), computed modulo 2^32 and read as a signed value. The counter value plus the signed sum of the emitted immediates equals label_addr_i.
- R4: An offset of zero or more uses opcode 4'b0100 (add). A negative offset uses opcode 4'b0010 (subtract) with the magnitude of the offset. Both words of a pair carry the same opcode.
- R5: Each emitted word is laid out as follows:
  - bits 31:28 = 4'b1110;
  - bits 27:26 = 2'b00;
  - bit 25 = 1;
  - bits 24:21 = opcode;
  - bit 20 = 0;
  - bits 19:16 = source register;
  - bits 15:12 = destination register;
  - bits 11:0 = unsigned immediate.
- R6: A magnitude of at most 255 gives count_o = 1 whatever long_i is. word0_o then has source register 15, destination dst_reg_i and the magnitude as its immediate, and word1_o is zero.
- R7: A magnitude above 255 with long_i low gives err_o = 1, count_o = 0 and both words zero.
- R8: With long_i high and a magnitude from 256 to 4350, count_o = 2. word0_o has source 15, destination dst_reg_i and immediate 255. word1_o has source and destination both dst_reg_i and immediate equal to the magnitude minus 255.
- R9: With long_i high and a magnitude above 4350, the remainder does not fit the 12-bit immediate field. The block then gives err_o = 1, count_o = 0 and both words zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request present this cycle |
| instr_addr_i | input | 32 | Address of the instruction being rewritten |
| label_addr_i | input | 32 | Address of the target label |
| dst_reg_i | input | 4 | Destination register number |
| long_i | input | 1 | Allow the two-instruction form |
| valid_o | output | 1 | Result present |
| word0_o | output | 32 | First instruction word |
| word1_o | output | 32 | Second instruction word, zero unless count_o is 2 |
| count_o | output | 2 | Number of valid instruction words (0, 1 or 2) |
| err_o | output | 1 | Offset out of range for the selected form |

## Verification
The bench covers the following input patterns:
- **Sign cases:** offsets just ahead of and just behind the counter, plus zero. These separate the add and subtract paths and show the zero case resolving to an add.
- **Short-form edge:** magnitudes of 255 and 256, with the long form on and off. These locate the single-instruction limit and show that a short offset ignores the long select.
- **Long-form edge:** long requests at 4300 and -4300, and at 4350 and 4351. These exercise the split and its upper edge.
- **Wrap-around:** an instruction address near the top of memory, which shows the offset is taken modulo 2^32.

For every emitted pair, the bench also rebuilds the label address from the counter value and the signed immediates.

// File: rtl/pcrel_pkg.sv
package pcrel_pkg;
  localparam int unsigned REG_W = 4;
  localparam int unsigned OPC_W = 4;
  localparam int unsigned IMM_W = 12;
  localparam int unsigned WORD_W = 32;

  localparam logic [3:0] COND_ALWAYS = 4'b1110;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'b0100;
  localparam logic [OPC_W-1:0] OPC_SUB = 4'b0010;
  localparam logic [REG_W-1:0] PC_REG = 4'd15;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] src;
    logic [REG_W-1:0] dst;
    logic [IMM_W-1:0] imm;
  } dp_fields_t;

  function automatic logic [WORD_W-1:0] pack_word(input dp_fields_t f);
    return {COND_ALWAYS, 2'b00, 1'b1, f.opc, 1'b0, f.src, f.dst, f.imm};
  endfunction
endpackage

// File: rtl/pcrel_offset.sv
module pcrel_offset #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PIPE_AHEAD = 8
) (
  input  logic [ADDR_W-1:0] instr_addr_i,
  input  logic [ADDR_W-1:0] label_addr_i,
  output logic              neg_o,
  output logic [ADDR_W-1:0] mag_o
);
  localparam logic [ADDR_W-1:0] AHEAD = ADDR_W'(PIPE_AHEAD);

  logic [ADDR_W-1:0] pc_view;
  logic [ADDR_W-1:0] diff;

  always_comb begin
    pc_view = instr_addr_i + AHEAD;
    diff    = label_addr_i - pc_view;
    neg_o   = diff[ADDR_W-1];
    mag_o   = neg_o ? (~diff + 1'b1) : diff;
  end
endmodule

// File: rtl/pcrel_split.sv
module pcrel_split #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SHORT_MAX = 255,
  parameter int unsigned IMM_W = 12
) (
  input  logic [ADDR_W-1:0] mag_i,
  input  logic              long_i,
  output logic [1:0]        cnt_o,
  output logic              err_o,
  output logic [IMM_W-1:0]  part0_o,
  output logic [IMM_W-1:0]  part1_o
);
  localparam logic [ADDR_W-1:0] SHORT_LIM = ADDR_W'(SHORT_MAX);
  localparam logic [ADDR_W-1:0] IMM_LIM   = ADDR_W'((1 << IMM_W) - 1);

  logic              fits_short;
  logic              fits_long;
  logic [ADDR_W-1:0] rem;

  always_comb begin
    fits_short = mag_i <= SHORT_LIM;
    rem        = mag_i - SHORT_LIM;
    fits_long  = rem <= IMM_LIM;
    cnt_o      = 2'd0;
    err_o      = 1'b0;
    part0_o    = '0;
    part1_o    = '0;
    if (fits_short) begin
      cnt_o   = 2'd1;
      part0_o = mag_i[IMM_W-1:0];
    end else if (long_i && fits_long) begin
      cnt_o   = 2'd2;
      part0_o = SHORT_LIM[IMM_W-1:0];
      part1_o = rem[IMM_W-1:0];
    end else begin
      err_o = 1'b1;
    end
  end
endmodule

// File: rtl/pcrel_encode.sv
module pcrel_encode
  import pcrel_pkg::*;
#(
  parameter int unsigned SLOT = 0
) (
  input  logic              en_i,
  input  logic              neg_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [WORD_W-1:0] word_o
);
  dp_fields_t f;

  always_comb begin
    f.opc  = neg_i ? OPC_SUB : OPC_ADD;
    // slot 0 reads the counter, slot 1 chains on the destination
    f.src  = (SLOT == 0) ? PC_REG : dst_i;
    f.dst  = dst_i;
    f.imm  = imm_i;
    word_o = en_i ? pack_word(f) : '0;
  end
endmodule

// File: rtl/pcrel_gen.sv
module pcrel_gen
  import pcrel_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PIPE_AHEAD = 8,
  parameter int unsigned SHORT_MAX = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] instr_addr_i,
  input  logic [ADDR_W-1:0] label_addr_i,
  input  logic [REG_W-1:0]  dst_reg_i,
  input  logic              long_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] word0_o,
  output logic [WORD_W-1:0] word1_o,
  output logic [1:0]        count_o,
  output logic              err_o
);
  localparam int unsigned SLOTS = 2;

  logic              neg;
  logic [ADDR_W-1:0] mag;
  logic [1:0]        cnt;
  logic              err;
  logic [IMM_W-1:0]  part [SLOTS];
  logic [WORD_W-1:0] word [SLOTS];

  pcrel_offset #(.ADDR_W(ADDR_W), .PIPE_AHEAD(PIPE_AHEAD)) u_offset (
    .instr_addr_i(instr_addr_i),
    .label_addr_i(label_addr_i),
    .neg_o       (neg),
    .mag_o       (mag)
  );

  pcrel_split #(.ADDR_W(ADDR_W), .SHORT_MAX(SHORT_MAX), .IMM_W(IMM_W)) u_split (
    .mag_i  (mag),
    .long_i (long_i),
    .cnt_o  (cnt),
    .err_o  (err),
    .part0_o(part[0]),
    .part1_o(part[1])
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    pcrel_encode #(.SLOT(s)) u_enc (
      .en_i  (cnt > 2'(s)),
      .neg_i (neg),
      .dst_i (dst_reg_i),
      .imm_i (part[s]),
      .word_o(word[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      word0_o <= '0;
      word1_o <= '0;
      count_o <= '0;
      err_o   <= 1'b0;
    end else if (valid_i) begin
      valid_o <= 1'b1;
      word0_o <= word[0];
      word1_o <= word[1];
      count_o <= cnt;
      err_o   <= err;
    end else begin
      valid_o <= 1'b0;
      word0_o <= '0;
      word1_o <= '0;
      count_o <= '0;
      err_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/pcrel_gen_chk.sv
module pcrel_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        long_i,
  input logic        valid_o,
  input logic [31:0] word0_o,
  input logic [31:0] word1_o,
  input logic [1:0]  count_o,
  input logic        err_o
);
  // R2
  p_valid_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && count_o == 2'd0 && !err_o));
  // R7, R9
  p_err_no_words_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (count_o == 2'd0 && word0_o == '0 && word1_o == '0));
  p_ok_has_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !err_o) |-> (count_o != 2'd0));
  // R6
  p_single_zero_tail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == 2'd1) |-> (word1_o == '0 && word0_o[19:16] == 4'd15));
  p_short_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !long_i) |=> (count_o != 2'd2));
  // R8
  p_chain_regs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == 2'd2) |-> (word0_o[19:16] == 4'd15 && word1_o[19:16] == word1_o[15:12]
                           && word0_o[15:12] == word1_o[15:12] && word0_o[11:0] == 12'd255));
  // R4
  p_same_opc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == 2'd2) |-> (word0_o[24:21] == word1_o[24:21]));
  // R5
  p_fixed_bits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != 2'd0) |-> (word0_o[31:25] == 7'b1110001 && word0_o[20] == 1'b0));
endmodule

bind pcrel_gen pcrel_gen_chk u_chk (.*);

// File: tb/pcrel_gen_tb.sv
module pcrel_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_addr_i = '0;
  logic [31:0] label_addr_i = '0;
  logic [3:0]  dst_reg_i = '0;
  logic        long_i = 1'b0;
  logic        valid_o;
  logic [31:0] word0_o;
  logic [31:0] word1_o;
  logic [1:0]  count_o;
  logic        err_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] w0;
    logic [31:0] w1;
    logic [1:0]  cnt;
    logic        err;
    logic [31:0] addr;
    logic [31:0] label;
    string       tag;
  } exp_t;

  exp_t q[$];

  always #2 clk = ~clk;

  pcrel_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .instr_addr_i(instr_addr_i), .label_addr_i(label_addr_i),
    .dst_reg_i(dst_reg_i), .long_i(long_i),
    .valid_o(valid_o), .word0_o(word0_o), .word1_o(word1_o),
    .count_o(count_o), .err_o(err_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [3:0] op, input logic [3:0] rn,
                                      input logic [3:0] rd, input logic [11:0] imm);
    return {4'b1110, 2'b00, 1'b1, op, 1'b0, rn, rd, imm};
  endfunction

  task automatic drive(input logic [31:0] addr, input logic [31:0] label,
                       input logic [3:0] rd, input logic lng, input string tag);
    exp_t e;
    logic [31:0] d;
    logic [31:0] mag;
    logic [3:0]  op;
    d   = label - addr - 32'd8;
    op  = d[31] ? 4'b0010 : 4'b0100;
    mag = d[31] ? -d : d;
    e.w0 = '0; e.w1 = '0; e.cnt = 2'd0; e.err = 1'b0;
    if (mag <= 32'd255) begin
      e.cnt = 2'd1;
      e.w0  = enc(op, 4'd15, rd, mag[11:0]);
    end else if (lng && (mag - 32'd255) <= 32'd4095) begin
      e.cnt = 2'd2;
      e.w0  = enc(op, 4'd15, rd, 12'd255);
      e.w1  = enc(op, rd, rd, 12'(mag - 32'd255));
    end else begin
      e.err = 1'b1;
    end
    e.addr = addr; e.label = label; e.tag = tag;
    @(negedge clk);
    valid_i = 1'b1; instr_addr_i = addr; label_addr_i = label;
    dst_reg_i = rd; long_i = lng;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0; long_i = 1'b0;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && valid_o) begin
        if (q.size() == 0) begin
          check(1'b0, "R2 unexpected valid_o", 32'(valid_o), 32'd0);
        end else begin
          exp_t e;
          logic [31:0] acc;
          e = q.pop_front();
          check(word0_o == e.w0, {e.tag, " word0"}, word0_o, e.w0);
          check(word1_o == e.w1, {e.tag, " word1"}, word1_o, e.w1);
          check(count_o == e.cnt, {e.tag, " count"}, 32'(count_o), 32'(e.cnt));
          check(err_o == e.err, {e.tag, " err"}, 32'(err_o), 32'(e.err));
          if (count_o != 2'd0) begin
            // R3: rebuild label from counter view and signed immediates
            acc = e.addr + 32'd8;
            acc = (word0_o[24:21] == 4'b0010) ? acc - 32'(word0_o[11:0]) : acc + 32'(word0_o[11:0]);
            if (count_o == 2'd2)
              acc = (word1_o[24:21] == 4'b0010) ? acc - 32'(word1_o[11:0]) : acc + 32'(word1_o[11:0]);
            check(acc == e.label, {e.tag, " R3 rebuilt label"}, acc, e.label);
          end
        end
      end else if (rst_n && q.size() != 0 && !done) begin
        check(1'b0, "R2 missing result", 32'(valid_o), 32'd1);
        void'(q.pop_front());
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R2 act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #7;
    // R1 reset state
    check(valid_o == 1'b0 && count_o == 2'd0 && err_o == 1'b0, "R1 reset ctl",
          {29'd0, valid_o, count_o}, 32'd0);
    check(word0_o == '0 && word1_o == '0, "R1 reset words", word0_o | word1_o, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    check(valid_o == 1'b0, "R1 idle after reset", 32'(valid_o), 32'd0);

    drive(32'h0000_1000, 32'h0000_1000 + 32'd8 - 32'd16, 4'd0, 1'b0, "R4 R6 sub 16");
    drive(32'h0000_1000, 32'h0000_1000 + 32'd8 + 32'd4, 4'd1, 1'b0, "R4 R6 add 4");
    drive(32'h0000_2000, 32'h0000_2008, 4'd2, 1'b0, "R4 zero add");
    drive(32'h0000_0100, 32'h0000_0108 + 32'd255, 4'd3, 1'b1, "R6 255 long ignored");
    drive(32'h0000_0100, 32'h0000_0108 - 32'd255, 4'd3, 1'b0, "R6 R4 -255");
    drive(32'h0000_0100, 32'h0000_0108 + 32'd256, 4'd4, 1'b0, "R7 256 short");
    drive(32'h0000_4000, 32'h0000_4008 - 32'd300, 4'd5, 1'b0, "R7 -300 short");
    drive(32'h0000_0200, 32'h0000_0208 + 32'd4300, 4'd2, 1'b1, "R8 4300 long");
    drive(32'h0000_8000, 32'h0000_8008 - 32'd4300, 4'd6, 1'b1, "R8 R4 -4300 long");
    drive(32'h0000_0000, 32'h0000_0008 + 32'd256, 4'd7, 1'b1, "R8 256 long");
    drive(32'h0000_0000, 32'h0000_0008 + 32'd4350, 4'd8, 1'b1, "R8 R9 4350 edge");
    drive(32'h0000_0000, 32'h0000_0008 + 32'd4351, 4'd8, 1'b1, "R9 4351 long");
    drive(32'h0001_0000, 32'h0000_0000, 4'd9, 1'b1, "R9 -65544 long");
    drive(32'hFFFF_FFF8, 32'h0000_0004, 4'd10, 1'b0, "R3 R5 wrap");
    idle(1);
    // R2: idle cycle gives cleared outputs
    @(posedge clk); #1;
    check(valid_o == 1'b0 && count_o == 2'd0 && err_o == 1'b0 && word0_o == '0,
          "R2 idle cleared", word0_o, 32'd0);
    drive(32'h0000_0300, 32'h0000_0308 + 32'd1000, 4'd11, 1'b1, "R2 after gap");
    idle(3);
    check(q.size() == 0, "R2 queue drained", 32'(q.size()), 32'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule